// File: doc/BRIEF.md
# Single-Slope Converter Counting Controller

This block holds the digital half of a single-slope integrating analog-to-digital converter. A start request clears the elapsed-time counter and the result counter. On the next clock it releases an external ramp generator. For each clock that the ramp runs, the elapsed-time counter advances. The result counter advances only on clocks where the external comparator reports that the held input is still above the ramp. The result counter therefore measures how long the ramp takes to reach the input.

A conversion finishes on the first clock where the comparator reads low. It also finishes when the elapsed-time counter reaches the last of its 2^N ticks while the comparator is still high. In that case the result saturates at all ones. When a conversion finishes, the ramp is put back into reset, the code is loaded into an output register and held there, and a completion flag is raised for one cycle. A start request that arrives while a conversion is running has no effect.

The comparator gate is a synchronous count enable. No clock is gated.

Top module: `ss_conv_ctrl`

## Requirements
- R1: Accepting a start clears both the elapsed-time counter and the result counter, so a conversion's code never includes counts left over from an earlier conversion.
- R2: `ramp_run` goes high on the clock edge that accepts `start` (while idle). It stays high through every tick of the conversion and returns low on the edge where the conversion finishes.
- R3: At each ramp tick where `cmp_hi` is 1, the result counter advances by one. At a tick where `cmp_hi` is 0, it does not advance. If the comparator is high on K consecutive ticks and then low, with K ≤ 2^N−1, the code equals K.
- R4: The first tick where `cmp_hi` is 0 ends the conversion. `done` and the new `code` are visible right after that edge. With start accepted at edge P0 and tick t at edge P0+1+t, this means after edge P0+1+K.
- R5: If `cmp_hi` is still 1 on tick 2^N−1 (the last tick of the elapsed-time counter), the conversion ends on that edge and `code` is all ones. No conversion runs longer than 2^N ticks.
- R6: `done` is high for exactly one cycle per conversion. `code` changes only on the edge where a conversion finishes and holds its value at all other times.
- R7: A `start` asserted while a conversion is running is ignored. It changes neither the code nor the length of that conversion.
- R8: After synchronous reset, `ramp_run`, `done` and `code` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all counters and the ramp tick |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_hi | input | 1 | Comparator: 1 while the held input is above the ramp |
| ramp_run | output | 1 | 1 releases the ramp to integrate, 0 holds it in reset |
| code | output | CODE_W | Latched conversion result |
| done | output | 1 | One-cycle pulse when `code` is updated |

## Verification
The bench drives a comparator model from a chosen input level K and sweeps K across every code of a 4-bit instance, plus several levels past full scale.

Each level is checked for:
- **Code value.** An off-by-one between the gate and the tick counter would shift every code by one, or lose the all-ones code at K = 15.
- **Finishing edge.** A design that failed to bound the interval would hang at K ≥ 16.
- **Saturation.** A design that let the result counter wrap would return small codes where all ones is expected.

One conversion receives an extra start pulse partway through. A controller that restarted on it would produce a longer conversion with a shifted code. A large level is followed immediately by a small one, which exposes a result counter that is not cleared on start.

// File: rtl/ss_conv_pkg.sv
package ss_conv_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Why a conversion ended on a given edge.
    typedef struct packed {
        logic hit;   // conversion finishes on this edge
        logic sat;   // interval ran out with comparator still high
    } conv_end_t;

    function automatic conv_end_t classify_end(input logic run,
                                               input logic cmp,
                                               input logic last_tick);
        conv_end_t e;
        e.hit = run && (!cmp || last_tick);
        e.sat = run && cmp && last_tick;
        return e;
    endfunction

endpackage

// File: rtl/ss_conv_seq.sv
module ss_conv_seq
    import ss_conv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic finish,
    output logic run,
    output logic clr
);

    seq_state_e state_q, state_d;

    assign clr = (state_q == SEQ_IDLE) && start;
    assign run = (state_q == SEQ_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start)  state_d = SEQ_RUN;
            SEQ_RUN:  if (finish) state_d = SEQ_IDLE;
            default:              state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run && start && !finish) |=> run); // R7

    AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        clr |=> run); // R2

endmodule

// File: rtl/ss_conv_ivl.sv
module ss_conv_ivl #(
    parameter int CODE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic last_tick
);

    localparam logic [CODE_W-1:0] IVL_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] ivl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) ivl_q <= '0;
        else if (run)   ivl_q <= ivl_q + 1'b1;
    end

    assign last_tick = run && (ivl_q == IVL_MAX);

    AST_IVL_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ivl_q == '0)); // R1

    AST_IVL_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !last_tick) |=> (ivl_q == CODE_W'($past(ivl_q) + 1'b1))); // R5

endmodule

// File: rtl/ss_conv_acc.sv
module ss_conv_acc #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] acc
);

    localparam logic [CODE_W-1:0] ACC_TOP = {CODE_W{1'b1}};

    logic [CODE_W-1:0] acc_q;
    logic              gate;

    // Synchronous count enable in place of a gated clock.
    assign gate = run && cmp_hi && (acc_q != ACC_TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else if (gate)  acc_q <= acc_q + 1'b1;
    end

    assign acc = acc_q;

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0)); // R1

    AST_ACC_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (run && !cmp_hi) |=> $stable(acc_q)); // R3

endmodule

// File: rtl/ss_conv_cap.sv
module ss_conv_cap
    import ss_conv_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  conv_end_t         fin,
    input  logic [CODE_W-1:0] acc,
    output logic [CODE_W-1:0] code,
    output logic              done
);

    logic [CODE_W-1:0] code_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin.hit;
            if (fin.hit) code_q <= fin.sat ? {CODE_W{1'b1}} : acc;
        end
    end

    assign code = code_q;
    assign done = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R6

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !fin.hit |=> $stable(code_q)); // R6

endmodule

// File: rtl/ss_conv_ctrl.sv
module ss_conv_ctrl
    import ss_conv_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmp_hi,
    output logic              ramp_run,
    output logic [CODE_W-1:0] code,
    output logic              done
);

    logic              run;
    logic              clr;
    logic              last_tick;
    logic [CODE_W-1:0] acc;
    conv_end_t         fin;

    assign fin = classify_end(run, cmp_hi, last_tick);

    ss_conv_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .finish (fin.hit),
        .run    (run),
        .clr    (clr)
    );

    ss_conv_ivl #(.CODE_W(CODE_W)) u_ivl (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .run       (run),
        .last_tick (last_tick)
    );

    ss_conv_acc #(.CODE_W(CODE_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .run    (run),
        .cmp_hi (cmp_hi),
        .acc    (acc)
    );

    ss_conv_cap #(.CODE_W(CODE_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .fin  (fin),
        .acc  (acc),
        .code (code),
        .done (done)
    );

    assign ramp_run = run;

    AST_RAMP_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !ramp_run); // R4

    AST_SAT_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && $past(cmp_hi)) |-> (code == {CODE_W{1'b1}})); // R5

endmodule

// File: tb/sim_ss_conv_ctrl.sv
module sim_ss_conv_ctrl;

    localparam int W    = 4;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp_hi = 1'b0;
    logic         ramp_run;
    logic [W-1:0] code;
    logic         done;

    int errors = 0;
    int checks = 0;
    int kval   = 0;
    int ticks  = 0;

    always #2.5 clk = ~clk;

    ss_conv_ctrl #(.CODE_W(W)) u0 (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_hi   (cmp_hi),
        .ramp_run (ramp_run),
        .code     (code),
        .done     (done)
    );

    // Comparator model: input level kval measured in ramp ticks.
    always @(negedge clk) begin
        if (!ramp_run) begin
            ticks  = 0;
            cmp_hi = 1'b0;
        end else begin
            cmp_hi = (ticks < kval);
            ticks  = ticks + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int k, input bit inject);
        int exp_t;
        int i;
        logic [W-1:0] held;
        exp_t = (k < MAXC) ? k : MAXC;
        @(negedge clk);
        kval  = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 ramp released", int'(ramp_run), 1);
        i = 1;
        while (1) begin
            @(negedge clk);
            i++;
            start = (inject && i == 4);
            if (done) break;
            if (!ramp_run) begin
                check("R2 ramp held during run", 0, 1);
                break;
            end
            if (i > 60) begin
                check("R5 conversion bounded", i, 2 + exp_t);
                break;
            end
        end
        start = 1'b0;
        if (inject) check("R7 length with stray start", i, 2 + exp_t);
        else if (k > MAXC) check("R5 length at saturation", i, 2 + exp_t);
        else check("R4 done timing", i, 2 + exp_t);
        if (k >= MAXC) check("R5 saturated code", int'(code), MAXC);
        else check("R3 code", int'(code), exp_t);
        check("R4 ramp down at done", int'(ramp_run), 0);
        held = code;
        @(negedge clk);
        check("R6 done single cycle", int'(done), 0);
        repeat (2) @(negedge clk);
        check("R6 code held", int'(code), int'(held));
        check("R6 stays idle", int'(ramp_run), 0);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 reset ramp_run", int'(ramp_run), 0);
        check("R8 reset done", int'(done), 0);
        check("R8 reset code", int'(code), 0);
        for (int k = 0; k <= 20; k++) convert(k, 1'b0);
        // R1: a large conversion followed by a small one
        convert(40, 1'b0);
        convert(3, 1'b0);
        // R7: stray start during a run
        convert(9, 1'b1);
        convert(0, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule